// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides what happens to one load in an out-of-order memory pipeline by comparing the load's byte range with the entries of a small store queue that are older than it. It has three outcomes. The load can take data forwarded from a store that holds every byte it needs, without a cache access. The load can be stalled because a store still in flight covers part of its bytes. Or the load can be issued to the cache because no store blocks it.

Locked (load-linked) loads are treated differently. They never take forwarded data and are stalled on any overlap with a pending older store. As a result, the cache always sees them and can set its reservation.

Loads enter through a valid/ready stream and are held in a single holding register. The held load is evaluated combinationally against the live store queue every cycle, so a stalled load is retried without any extra action. Results leave on a second valid/ready stream, which asserts valid only for a final outcome (forward or cache). A held load blocks new loads until its result is taken. While the result stream is held off, the reported outcome follows the current store queue contents, so it may change if a store drains in that window.

Top module: `ldfwd_check`

## Requirements
- R1: After reset no load is held, `ld_ready` is 1, `res_valid` is 0 and `res_code` is 2'b00 (idle).
- R2: A normal load whose bytes all lie inside an older store's range gets code 2'b01 (forward) with `res_valid` 1. `res_data` byte k equals store data byte (k + load address − store address) for k below the load size, and its upper bytes are zero.
- R3: A normal load that overlaps an older, not-written-back store only in part gets code 2'b11 (stall) with `res_valid` 0. This covers overlap at the low end, overlap at the high end, and a load that spans the store.
- R4: A locked load (`ld_locked` 1) is never given code 2'b01. Any overlap with an older, not-written-back store, full containment included, gives code 2'b11.
- R5: A held load that overlaps no valid, older store gets code 2'b10 (cache) with `res_valid` 1. Entries whose `sq_valid` or `sq_older` bit is 0 are ignored. Adjacent ranges (load end equal to store start) do not overlap.
- R6: A store with `sq_wb` 1 never causes a stall, and the search continues past it to older stores. A normal load fully inside such a store is still forwarded from it.
- R7: Entry index order is age order, with a higher index being younger. The youngest older store that overlaps (and is not skipped under R6) alone decides the outcome.
- R8: A stalled load stays held and is re-evaluated every cycle. In the same cycle that the blocking store is cleared or marked written back, the outcome changes.
- R9: `ld_ready` is 1 exactly when no load is held or the held load's result is taken that cycle. An accepted load is held from the next cycle. A held load stays, with its address unchanged, until its result is taken.
- R10: `ld_size` and each store size code s mean 2^s bytes (1, 2, 4 or 8). Range ends are computed one bit wider than the address, so ranges do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high with `ld_valid` |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code (2^s bytes) |
| ld_locked | input | 1 | Load is a locked (load-linked) load |
| sq_valid | input | DEPTH | Store entry holds a store |
| sq_older | input | DEPTH | Store entry is older than the load |
| sq_wb | input | DEPTH | Store entry already written back to memory |
| sq_addr | input | DEPTH*ADDR_W | Store byte addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| sq_size | input | DEPTH*2 | Store size codes, entry i at bits [2i +: 2] |
| sq_data | input | DEPTH*DATA_W | Store data, byte 0 at the least significant end |
| res_valid | output | 1 | Final result (forward or cache) available |
| res_ready | input | 1 | Result consumer ready |
| res_code | output | 2 | 00 idle, 01 forward, 10 cache, 11 stall |
| res_data | output | DATA_W | Forwarded data aligned to the load's byte 0 |

## Verification
Each case places a store and a normal or locked load so that each of the four range comparisons is exercised on both sides. The cases are full containment at each byte offset, overlap at the low end, overlap at the high end, a load spanning the store, and exactly adjacent ranges. Telling forward apart from stall under containment shows whether the locked flag is honoured. The adjacent cases show whether the comparisons are strict or inclusive. Further patterns stack a younger and an older store with different outcomes, which shows whether the search goes youngest first. Written-back stores, and entries that are invalid or not older, show which entries may take part. Draining a store during a stall, and holding off the result stream, show the retry behaviour and the hand-off rules.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;

  typedef enum logic [1:0] {
    RES_IDLE  = 2'b00,
    RES_FWD   = 2'b01,
    RES_CACHE = 2'b10,
    RES_STALL = 2'b11
  } res_code_e;

  // size code s -> 2^s bytes
  function automatic logic [3:0] size_bytes(input logic [1:0] s);
    return 4'd1 << s;
  endfunction

endpackage

// File: rtl/ldfwd_range_cmp.sv
// Compares a load's byte range against one store entry (R3, R4, R5, R6, R10).
module ldfwd_range_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_locked,
  input  logic              st_valid,
  input  logic              st_older,
  input  logic              st_wb,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  output logic              hit,
  output logic              fwd_ok
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic starts_in, ends_in, lo_below_end, hi_above_start;
  logic full, overlap, live;

  always_comb begin
    ld_lo = {1'b0, ld_addr};
    st_lo = {1'b0, st_addr};
    ld_hi = ld_lo + {{(EXT_W-4){1'b0}}, ldfwd_pkg::size_bytes(ld_size)};
    st_hi = st_lo + {{(EXT_W-4){1'b0}}, ldfwd_pkg::size_bytes(st_size)};
  end

  assign starts_in      = ld_lo >= st_lo;
  assign ends_in        = ld_hi <= st_hi;
  assign lo_below_end   = ld_lo <  st_hi;
  assign hi_above_start = ld_hi >  st_lo;

  assign full    = starts_in & ends_in;
  assign overlap = lo_below_end & hi_above_start;
  assign live    = st_valid & st_older;
  assign fwd_ok  = full & ~ld_locked;
  // a written-back store only matters when it can forward
  assign hit     = live & overlap & (fwd_ok | ~st_wb);
endmodule

// File: rtl/ldfwd_pick.sv
// Youngest-first priority select over hit flags (R7).
module ldfwd_pick #(
  parameter int DEPTH = 8,
  parameter int SEL_W = 3
) (
  input  logic [DEPTH-1:0] hit,
  output logic             any,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) begin
        any = 1'b1;
        sel = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/ldfwd_align.sv
// Shifts store data down to the load's byte 0 and clears bytes past the load size (R2).
module ldfwd_align #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [OFS_W-1:0]  shift,
  input  logic [1:0]        ld_size,
  output logic [DATA_W-1:0] data_out
);
  localparam int BYTES = DATA_W / 8;

  logic [3:0] nbytes;
  assign nbytes = ldfwd_pkg::size_bytes(ld_size);

  always_comb begin
    data_out = '0;
    for (int b = 0; b < BYTES; b++) begin
      if ((b < int'(nbytes)) && (b + int'(shift) < BYTES))
        data_out[8*b +: 8] = st_data[8*(b + int'(shift)) +: 8];
    end
  end
endmodule

// File: rtl/ldfwd_check.sv
module ldfwd_check #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [1:0]                ld_size,
  input  logic                      ld_locked,
  input  logic [DEPTH-1:0]          sq_valid,
  input  logic [DEPTH-1:0]          sq_older,
  input  logic [DEPTH-1:0]          sq_wb,
  input  logic [DEPTH*ADDR_W-1:0]   sq_addr,
  input  logic [DEPTH*2-1:0]        sq_size,
  input  logic [DEPTH*DATA_W-1:0]   sq_data,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [1:0]                res_code,
  output logic [DATA_W-1:0]         res_data
);
  import ldfwd_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // holding register for the load under evaluation
  logic              hold_vld;
  logic [ADDR_W-1:0] hold_addr;
  logic [1:0]        hold_size;
  logic              hold_lock;

  logic              take_ld, take_res;
  assign take_res = res_valid & res_ready;
  assign ld_ready = ~hold_vld | take_res;
  assign take_ld  = ld_valid & ld_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_size <= '0;
      hold_lock <= 1'b0;
    end else begin
      if (take_ld) begin
        hold_vld  <= 1'b1;
        hold_addr <= ld_addr;
        hold_size <= ld_size;
        hold_lock <= ld_locked;
      end else if (take_res) begin
        hold_vld  <= 1'b0;
      end
    end
  end

  // per-entry comparison
  logic [DEPTH-1:0]  hit, fwd_ok;
  logic [OFS_W-1:0]  st_ofs  [DEPTH];
  logic [DATA_W-1:0] st_dat  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign st_ofs[i] = sq_addr[i*ADDR_W +: OFS_W];
    assign st_dat[i] = sq_data[i*DATA_W +: DATA_W];

    ldfwd_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .ld_addr   (hold_addr),
      .ld_size   (hold_size),
      .ld_locked (hold_lock),
      .st_valid  (sq_valid[i]),
      .st_older  (sq_older[i]),
      .st_wb     (sq_wb[i]),
      .st_addr   (sq_addr[i*ADDR_W +: ADDR_W]),
      .st_size   (sq_size[2*i +: 2]),
      .hit       (hit[i]),
      .fwd_ok    (fwd_ok[i])
    );
  end

  logic             any_hit;
  logic [SEL_W-1:0] sel;

  ldfwd_pick #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_pick (
    .hit (hit),
    .any (any_hit),
    .sel (sel)
  );

  logic [OFS_W-1:0]  shift;
  logic [DATA_W-1:0] aligned;
  assign shift = hold_addr[OFS_W-1:0] - st_ofs[sel];

  ldfwd_align #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_align (
    .st_data  (st_dat[sel]),
    .shift    (shift),
    .ld_size  (hold_size),
    .data_out (aligned)
  );

  res_code_e code;
  always_comb begin
    if (!hold_vld)         code = RES_IDLE;
    else if (!any_hit)     code = RES_CACHE;
    else if (fwd_ok[sel])  code = RES_FWD;
    else                   code = RES_STALL;
  end

  assign res_code  = code;
  assign res_valid = hold_vld & (code != RES_STALL);
  assign res_data  = (code == RES_FWD) ? aligned : '0;
endmodule

// File: rtl/ldfwd_check_sva.sv
module ldfwd_check_sva #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_code,
  input logic              hold_vld,
  input logic [ADDR_W-1:0] hold_addr,
  input logic              hold_lock,
  input logic [DEPTH-1:0]  sq_valid,
  input logic [DEPTH-1:0]  sq_older
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_vld |-> (!res_valid && res_code == 2'b00 && ld_ready));

  assert_locked_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lock |-> res_code != 2'b01);

  assert_stall_not_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_code == 2'b11 |-> !res_valid);

  assert_empty_goes_cache_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && (sq_valid & sq_older) == '0) |-> res_code == 2'b10);

  assert_stall_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && res_code == 2'b11) |=> (hold_vld && $stable(hold_addr)));

  assert_accept_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> hold_vld);

  assert_wait_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !(res_valid && res_ready)) |=> (hold_vld && $stable(hold_addr)));
endmodule

bind ldfwd_check ldfwd_check_sva #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_code  (res_code),
  .hold_vld  (hold_vld),
  .hold_addr (hold_addr),
  .hold_lock (hold_lock),
  .sq_valid  (sq_valid),
  .sq_older  (sq_older)
);

// File: tb/ldfwd_check_test.sv
`timescale 1ns/1ps
module ldfwd_check_test;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic                    ld_valid = 1'b0;
  logic                    ld_ready;
  logic [ADDR_W-1:0]       ld_addr = '0;
  logic [1:0]              ld_size = '0;
  logic                    ld_locked = 1'b0;
  logic [DEPTH-1:0]        b_valid = '0, b_older = '0, b_wb = '0;
  logic [ADDR_W-1:0]       b_addr [DEPTH];
  logic [1:0]              b_size [DEPTH];
  logic [DATA_W-1:0]       b_data [DEPTH];
  logic [DEPTH*ADDR_W-1:0] sq_addr;
  logic [DEPTH*2-1:0]      sq_size;
  logic [DEPTH*DATA_W-1:0] sq_data;
  logic                    res_valid;
  logic                    res_ready = 1'b1;
  logic [1:0]              res_code;
  logic [DATA_W-1:0]       res_data;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sq_addr[i*ADDR_W +: ADDR_W] = b_addr[i];
      sq_size[2*i +: 2]           = b_size[i];
      sq_data[i*DATA_W +: DATA_W] = b_data[i];
    end
  end

  ldfwd_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_size(ld_size), .ld_locked(ld_locked),
    .sq_valid(b_valid), .sq_older(b_older), .sq_wb(b_wb),
    .sq_addr(sq_addr), .sq_size(sq_size), .sq_data(sq_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_data(res_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit          m_hold = 1'b0;
  longint      m_addr = 0;
  int          m_size = 0;
  bit          m_lock = 1'b0;

  // behavioural outcome: 0 idle, 1 forward, 2 cache, 3 stall
  function automatic void ref_decide(output logic [1:0] code, output logic [63:0] data);
    longint ls, le, ss, se;
    code = 2'd2;
    data = '0;
    if (!m_hold) begin code = 2'd0; return; end
    ls = m_addr;
    le = m_addr + (longint'(1) << m_size);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!(b_valid[i] && b_older[i])) continue;
      ss = longint'(b_addr[i]);
      se = ss + (longint'(1) << b_size[i]);
      if (!(ls < se && le > ss)) continue;
      if (ls >= ss && le <= se && !m_lock) begin
        code = 2'd1;
        for (int k = 0; k < (1 << m_size); k++)
          data[8*k +: 8] = b_data[i][8*int'(ls - ss + k) +: 8];
        return;
      end
      if (b_wb[i]) continue;
      code = 2'd3;
      return;
    end
  endfunction

  task automatic tick(input string tag);
    logic [1:0]  ec;
    logic [63:0] ed;
    logic ev, er, acc_res, acc_ld;
    #1;
    ref_decide(ec, ed);
    ev = m_hold && (ec != 2'd3);
    er = !m_hold || (ev && res_ready);
    checks++;
    if (ld_ready !== er || res_valid !== ev || res_code !== ec ||
        (ev && res_data !== ed)) begin
      errors++;
      $display("FAIL %s: ready=%b valid=%b code=%0d data=%h expected ready=%b valid=%b code=%0d data=%h",
               tag, ld_ready, res_valid, res_code, res_data, er, ev, ec, ed);
    end
    acc_res = ev && res_ready;
    acc_ld  = ld_valid && er;
    @(posedge clk);
    if (acc_res) m_hold = 1'b0;
    if (acc_ld) begin
      m_hold = 1'b1; m_addr = longint'(ld_addr); m_size = int'(ld_size); m_lock = ld_locked;
    end
    #1;
  endtask

  task automatic clear_sq();
    b_valid = '0; b_older = '0; b_wb = '0;
  endtask

  task automatic put_store(input int i, input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
    b_valid[i] = 1'b1; b_older[i] = 1'b1; b_wb[i] = 1'b0;
    b_addr[i] = a; b_size[i] = s; b_data[i] = d;
  endtask

  // present a load for one cycle, then observe its first result cycle
  task automatic load(input logic [31:0] a, input logic [1:0] s, input logic lk, input string tag);
    ld_valid = 1'b1; ld_addr = a; ld_size = s; ld_locked = lk;
    tick(tag);
    ld_valid = 1'b0;
    tick(tag);
  endtask

  localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      b_addr[i] = '0; b_size[i] = '0; b_data[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick("R1 reset idle");
    tick("R1 reset idle");

    // R2 full containment at several offsets and sizes
    clear_sq();
    put_store(2, 32'h100, 2'd3, PAT);
    load(32'h102, 2'd1, 1'b0, "R2 fwd half at offset 2");
    load(32'h100, 2'd3, 1'b0, "R2 fwd whole store");
    load(32'h107, 2'd0, 1'b0, "R2 fwd last byte");
    load(32'h104, 2'd2, 1'b0, "R2 R10 fwd word at offset 4");

    // R3 low-end partial, then drain by write-back (R6, R8)
    clear_sq();
    put_store(3, 32'h104, 2'd2, PAT);
    load(32'h102, 2'd2, 1'b0, "R3 low-end partial stall");
    tick("R8 still stalled");
    b_wb[3] = 1'b1;
    tick("R6 R8 written back releases to cache");
    tick("R6 after release");

    // R3 high-end partial, then drain by clearing valid
    clear_sq();
    put_store(1, 32'h100, 2'd2, PAT);
    load(32'h102, 2'd2, 1'b0, "R3 high-end partial stall");
    b_valid[1] = 1'b0;
    tick("R8 cleared entry releases to cache");
    tick("R8 after release");

    // R3 load spans the store
    clear_sq();
    put_store(4, 32'h102, 2'd1, PAT);
    load(32'h100, 2'd3, 1'b0, "R3 spanning stall");
    b_wb[4] = 1'b1;
    tick("R6 spanning released");
    tick("R6 after release");

    // R4 locked load in each case
    clear_sq();
    put_store(2, 32'h100, 2'd3, PAT);
    load(32'h102, 2'd1, 1'b1, "R4 locked full containment stalls");
    b_wb[2] = 1'b1;
    tick("R4 R6 locked released to cache by write-back");
    tick("R4 after release");
    clear_sq();
    put_store(2, 32'h104, 2'd2, PAT);
    load(32'h102, 2'd2, 1'b1, "R4 locked low-end stall");
    b_valid[2] = 1'b0;
    tick("R4 locked released");
    put_store(2, 32'h100, 2'd2, PAT);
    load(32'h102, 2'd2, 1'b1, "R4 locked high-end stall");
    b_valid[2] = 1'b0;
    tick("R4 locked released");
    put_store(2, 32'h102, 2'd1, PAT);
    load(32'h100, 2'd3, 1'b1, "R4 locked spanning stall");
    b_valid[2] = 1'b0;
    tick("R4 locked released");
    tick("R4 after release");

    // R5 adjacency and ignored entries
    clear_sq();
    put_store(0, 32'h100, 2'd2, PAT);
    load(32'h104, 2'd2, 1'b0, "R5 adjacent above goes to cache");
    load(32'h0FC, 2'd2, 1'b1, "R5 adjacent below goes to cache");
    b_older[0] = 1'b0;
    load(32'h100, 2'd2, 1'b0, "R5 younger entry ignored");
    b_older[0] = 1'b1; b_valid[0] = 1'b0;
    load(32'h100, 2'd2, 1'b0, "R5 invalid entry ignored");

    // R6 written-back full store still forwards
    clear_sq();
    put_store(5, 32'h200, 2'd3, PAT);
    b_wb[5] = 1'b1;
    load(32'h203, 2'd0, 1'b0, "R6 written-back store forwards");

    // R7 youngest decides
    clear_sq();
    put_store(1, 32'h300, 2'd3, 64'hA1A2_A3A4_A5A6_A7A8);
    put_store(6, 32'h304, 2'd2, 64'hB1B2_B3B4_B5B6_B7B8);
    load(32'h302, 2'd2, 1'b0, "R7 younger partial stalls over older full");
    b_wb[6] = 1'b1;
    tick("R7 skipped written-back younger, older forwards");
    tick("R7 after release");
    clear_sq();
    put_store(1, 32'h300, 2'd1, 64'hA1A2_A3A4_A5A6_A7A8);
    put_store(6, 32'h300, 2'd3, 64'hB1B2_B3B4_B5B6_B7B8);
    load(32'h300, 2'd2, 1'b0, "R7 younger full forwards over older partial");

    // R9 back-pressure on the result stream
    res_ready = 1'b0;
    load(32'h301, 2'd0, 1'b0, "R9 result held");
    ld_valid = 1'b1; ld_addr = 32'h500; ld_size = 2'd0; ld_locked = 1'b0;
    tick("R9 new load blocked while result waits");
    res_ready = 1'b1;
    tick("R9 result taken and next load accepted");
    ld_valid = 1'b0;
    tick("R9 second load goes to cache");
    tick("R9 idle again");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule